// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This block takes a trap into account. When a trap strobe arrives with a cause word, the faulting program counter and an optional bad address, the block picks the privilege mode that handles the trap. It makes the choice per cause, using one delegation mask for exceptions and another for interrupts. It then commits the whole entry sequence in one clock edge: the next program counter, the trap record of the chosen mode, the interrupt-enable stack and the privilege level.

The surrounding core supplies the live privilege level, the three live interrupt-enable bits, both delegation masks and both trap vectors. The block holds the trap records and the stacked status fields, and it presents them on its outputs. It also pulses a one-cycle signal that cancels any outstanding load reservation. Detecting exceptions and returning from traps are handled elsewhere.

Privilege levels use the codes user = 0, supervisor = 1, machine = 3. The enable vector `cur_ie_i` / `ie_o` holds the user enable in bit 0, the supervisor enable in bit 1 and the machine enable in bit 2.

Top module: `trap_entry_unit`

## Requirements
- R1: When bit XLEN-1 of the cause is 1, the trap is an interrupt. Its index is the cause with that bit cleared, and the interrupt mask is consulted. Otherwise the whole cause is the index and the exception mask is consulted.
- R2: The trap goes to supervisor (priv_o = 1) only when all three hold: `cur_priv_i` is 0 or 1, the index is below XLEN, and the consulted mask bit at that index is 1. In every other case, including `cur_priv_i` = 2, it goes to machine (priv_o = 3).
- R3: On a supervisor entry, pc_o takes `stvec_i`, scause_o takes the full cause and sepc_o takes the faulting PC. The machine record is left unchanged.
- R4: On a machine entry, pc_o takes `mtvec_i`, mcause_o takes the full cause and mepc_o takes the faulting PC. The supervisor record is left unchanged.
- R5: The target mode's bad-address output is written only when `badaddr_valid_i` is 1. The other mode's bad-address output never changes on that trap.
- R6: The target mode's previous-enable output receives the enable bit of the privilege being left. Privilege 0 reads bit 0, privilege 1 reads bit 1, and privileges 2 and 3 read bit 2.
- R7: A supervisor entry stores bit 0 of `cur_priv_i` in spp_o; a machine entry stores all 2 bits of `cur_priv_i` in mpp_o. ie_o takes `cur_ie_i` with the target mode's bit (1 or 2) cleared.
- R8: Every update of a trap becomes visible on the clock edge that samples `trap_i` high. resv_cancel_o is 1 in exactly the cycle after each such edge.
- R9: In a cycle where `trap_i` is low, no output changes, and resv_cancel_o is 0 in the cycle after that edge.
- R10: After reset, priv_o = 3, pc_o = RESET_PC, and every other output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_i | input | 1 | Trap strobe, one entry per high cycle |
| cause_i | input | XLEN | Trap cause; the top bit marks an interrupt |
| epc_i | input | XLEN | PC of the trapping instruction |
| badaddr_i | input | XLEN | Faulting address |
| badaddr_valid_i | input | 1 | badaddr_i carries a value for this trap |
| medeleg_i | input | XLEN | Exception delegation mask |
| mideleg_i | input | XLEN | Interrupt delegation mask |
| stvec_i | input | XLEN | Supervisor trap vector |
| mtvec_i | input | XLEN | Machine trap vector |
| cur_priv_i | input | 2 | Live privilege level |
| cur_ie_i | input | 3 | Live enables {machine, supervisor, user} |
| pc_o | output | XLEN | Next program counter after entry |
| priv_o | output | 2 | Privilege after the last entry |
| ie_o | output | 3 | Enable bits after the last entry |
| spie_o | output | 1 | Supervisor previous-enable |
| spp_o | output | 1 | Supervisor previous-privilege |
| mpie_o | output | 1 | Machine previous-enable |
| mpp_o | output | 2 | Machine previous-privilege |
| scause_o | output | XLEN | Supervisor cause |
| sepc_o | output | XLEN | Supervisor exception PC |
| sbadaddr_o | output | XLEN | Supervisor bad address |
| mcause_o | output | XLEN | Machine cause |
| mepc_o | output | XLEN | Machine exception PC |
| mbadaddr_o | output | XLEN | Machine bad address |
| resv_cancel_o | output | 1 | Load reservation cancel pulse |

## Verification
The bench builds the block with XLEN = 32 and RESET_PC = 0x100. With a 32-bit cause, an exception index of 40 and an interrupt cause of 0x8000_0040 are both easy to reach. Both indices lie past the mask width, so the out-of-range path of the routing is exercised next to the in-range path. The small width also lets random causes in the range 0 to 47 hit masked, unmasked and out-of-range indices for each of the four privilege codes.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;
  localparam logic [1:0] PRV_U = 2'd0;
  localparam logic [1:0] PRV_S = 2'd1;
  localparam logic [1:0] PRV_M = 2'd3;

  localparam int unsigned IE_U = 0;
  localparam int unsigned IE_S = 1;
  localparam int unsigned IE_M = 2;
  localparam int unsigned NUM_MODES = 2; // 0: supervisor record, 1: machine record

  // enable bit of the privilege being left; codes 2 and 3 read the machine bit
  function automatic logic ie_of_priv(input logic [1:0] prv, input logic [2:0] ie);
    case (prv)
      PRV_U:   return ie[IE_U];
      PRV_S:   return ie[IE_S];
      default: return ie[IE_M];
    endcase
  endfunction
endpackage

// File: rtl/trap_route.sv
module trap_route import trap_entry_pkg::*; #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] cause_i,
  input  logic [XLEN-1:0] medeleg_i,
  input  logic [XLEN-1:0] mideleg_i,
  input  logic [1:0]      cur_priv_i,
  output logic            to_sup_o
);
  localparam int unsigned IDXW = $clog2(XLEN);
  localparam logic [XLEN-1:0] LIMIT = XLEN[XLEN-1:0];

  logic            is_irq;
  logic [XLEN-1:0] idx;
  logic [XLEN-1:0] mask;
  logic            in_range;
  logic            low_priv;

  always_comb begin
    is_irq         = cause_i[XLEN-1];
    idx            = cause_i;
    idx[XLEN-1]    = 1'b0;
    mask           = is_irq ? mideleg_i : medeleg_i;
    in_range       = idx < LIMIT;
    low_priv       = (cur_priv_i == PRV_U) || (cur_priv_i == PRV_S);
    to_sup_o       = low_priv && in_range && mask[idx[IDXW-1:0]];
  end
endmodule

// File: rtl/trap_record.sv
module trap_record #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic            bad_wr_i,
  input  logic [XLEN-1:0] cause_i,
  input  logic [XLEN-1:0] epc_i,
  input  logic [XLEN-1:0] bad_i,
  output logic [XLEN-1:0] cause_o,
  output logic [XLEN-1:0] epc_o,
  output logic [XLEN-1:0] bad_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_o <= '0;
      epc_o   <= '0;
      bad_o   <= '0;
    end else if (wr_i) begin
      cause_o <= cause_i;
      epc_o   <= epc_i;
      if (bad_wr_i) bad_o <= bad_i;
    end
  end
endmodule

// File: rtl/trap_status_stack.sv
module trap_status_stack import trap_entry_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       trap_i,
  input  logic       to_sup_i,
  input  logic [1:0] cur_priv_i,
  input  logic [2:0] cur_ie_i,
  output logic [1:0] priv_o,
  output logic [2:0] ie_o,
  output logic       spie_o,
  output logic       spp_o,
  output logic       mpie_o,
  output logic [1:0] mpp_o
);
  logic       left_ie;
  logic [2:0] ie_next;

  always_comb begin
    left_ie = ie_of_priv(cur_priv_i, cur_ie_i);
    ie_next = cur_ie_i;
    if (to_sup_i) ie_next[IE_S] = 1'b0;
    else          ie_next[IE_M] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      priv_o <= PRV_M;
      ie_o   <= '0;
      spie_o <= 1'b0;
      spp_o  <= 1'b0;
      mpie_o <= 1'b0;
      mpp_o  <= '0;
    end else if (trap_i) begin
      ie_o <= ie_next;
      if (to_sup_i) begin
        spie_o <= left_ie;
        spp_o  <= cur_priv_i[0];
        priv_o <= PRV_S;
      end else begin
        mpie_o <= left_ie;
        mpp_o  <= cur_priv_i;
        priv_o <= PRV_M;
      end
    end
  end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit import trap_entry_pkg::*; #(
  parameter int unsigned     XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = 'h100
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            trap_i,
  input  logic [XLEN-1:0] cause_i,
  input  logic [XLEN-1:0] epc_i,
  input  logic [XLEN-1:0] badaddr_i,
  input  logic            badaddr_valid_i,
  input  logic [XLEN-1:0] medeleg_i,
  input  logic [XLEN-1:0] mideleg_i,
  input  logic [XLEN-1:0] stvec_i,
  input  logic [XLEN-1:0] mtvec_i,
  input  logic [1:0]      cur_priv_i,
  input  logic [2:0]      cur_ie_i,
  output logic [XLEN-1:0] pc_o,
  output logic [1:0]      priv_o,
  output logic [2:0]      ie_o,
  output logic            spie_o,
  output logic            spp_o,
  output logic            mpie_o,
  output logic [1:0]      mpp_o,
  output logic [XLEN-1:0] scause_o,
  output logic [XLEN-1:0] sepc_o,
  output logic [XLEN-1:0] sbadaddr_o,
  output logic [XLEN-1:0] mcause_o,
  output logic [XLEN-1:0] mepc_o,
  output logic [XLEN-1:0] mbadaddr_o,
  output logic            resv_cancel_o
);
  logic            to_sup;
  logic [XLEN-1:0] rec_cause [NUM_MODES];
  logic [XLEN-1:0] rec_epc   [NUM_MODES];
  logic [XLEN-1:0] rec_bad   [NUM_MODES];

  trap_route #(.XLEN(XLEN)) u_route (
    .cause_i    (cause_i),
    .medeleg_i  (medeleg_i),
    .mideleg_i  (mideleg_i),
    .cur_priv_i (cur_priv_i),
    .to_sup_o   (to_sup)
  );

  trap_status_stack u_stack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trap_i     (trap_i),
    .to_sup_i   (to_sup),
    .cur_priv_i (cur_priv_i),
    .cur_ie_i   (cur_ie_i),
    .priv_o     (priv_o),
    .ie_o       (ie_o),
    .spie_o     (spie_o),
    .spp_o      (spp_o),
    .mpie_o     (mpie_o),
    .mpp_o      (mpp_o)
  );

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_rec
    logic sel;
    assign sel = (m == 0) ? to_sup : !to_sup;
    trap_record #(.XLEN(XLEN)) u_rec (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (trap_i && sel),
      .bad_wr_i (badaddr_valid_i),
      .cause_i  (cause_i),
      .epc_i    (epc_i),
      .bad_i    (badaddr_i),
      .cause_o  (rec_cause[m]),
      .epc_o    (rec_epc[m]),
      .bad_o    (rec_bad[m])
    );
  end

  assign scause_o   = rec_cause[0];
  assign sepc_o     = rec_epc[0];
  assign sbadaddr_o = rec_bad[0];
  assign mcause_o   = rec_cause[1];
  assign mepc_o     = rec_epc[1];
  assign mbadaddr_o = rec_bad[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o          <= RESET_PC;
      resv_cancel_o <= 1'b0;
    end else begin
      resv_cancel_o <= trap_i;
      if (trap_i) pc_o <= to_sup ? stvec_i : mtvec_i;
    end
  end
endmodule

// File: rtl/trap_entry_unit_chk.sv
module trap_entry_unit_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            trap_i,
  input logic [XLEN-1:0] epc_i,
  input logic            badaddr_valid_i,
  input logic [1:0]      cur_priv_i,
  input logic [1:0]      priv_o,
  input logic [2:0]      ie_o,
  input logic [XLEN-1:0] scause_o,
  input logic [XLEN-1:0] sepc_o,
  input logic [XLEN-1:0] sbadaddr_o,
  input logic [XLEN-1:0] mcause_o,
  input logic [XLEN-1:0] mepc_o,
  input logic [XLEN-1:0] mbadaddr_o,
  input logic            resv_cancel_o
);
  AST_TARGET_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> (priv_o == 2'd1 || priv_o == 2'd3)); // R2

  AST_HIGH_PRIV_STAYS_M: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_i && cur_priv_i[1]) |=> priv_o == 2'd3); // R2

  AST_EPC_S: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> (priv_o != 2'd1 || sepc_o == $past(epc_i))); // R3

  AST_EPC_M: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> (priv_o != 2'd3 || mepc_o == $past(epc_i))); // R4

  AST_BAD_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_i && !badaddr_valid_i) |=> ($stable(sbadaddr_o) && $stable(mbadaddr_o))); // R5

  AST_TARGET_IE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> (priv_o == 2'd1 ? !ie_o[1] : !ie_o[2])); // R7

  AST_RESV_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> resv_cancel_o); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_i |=> (!resv_cancel_o && $stable(priv_o) && $stable(scause_o) && $stable(mcause_o)
                 && $stable(sepc_o) && $stable(mepc_o))); // R9
endmodule

bind trap_entry_unit trap_entry_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .trap_i          (trap_i),
  .epc_i           (epc_i),
  .badaddr_valid_i (badaddr_valid_i),
  .cur_priv_i      (cur_priv_i),
  .priv_o          (priv_o),
  .ie_o            (ie_o),
  .scause_o        (scause_o),
  .sepc_o          (sepc_o),
  .sbadaddr_o      (sbadaddr_o),
  .mcause_o        (mcause_o),
  .mepc_o          (mepc_o),
  .mbadaddr_o      (mbadaddr_o),
  .resv_cancel_o   (resv_cancel_o)
);

// File: tb/trap_entry_unit_tb_top.sv
`timescale 1ns/1ps
module trap_entry_unit_tb_top;
  localparam int unsigned XLEN = 32;
  localparam logic [31:0] RPC = 32'h100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        trap = 1'b0, bv = 1'b0;
  logic [31:0] cause = '0, epc = '0, bad = '0, medeleg = '0, mideleg = '0, stvec = '0, mtvec = '0;
  logic [1:0]  cpriv = 2'd3;
  logic [2:0]  cie = '0;

  logic [31:0] pc_o, sc_o, se_o, sb_o, mc_o, me_o, mb_o;
  logic [1:0]  priv_o, mpp_o;
  logic [2:0]  ie_o;
  logic        spie_o, spp_o, mpie_o, resv_o;

  trap_entry_unit #(.XLEN(XLEN), .RESET_PC(RPC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .trap_i(trap), .cause_i(cause), .epc_i(epc),
    .badaddr_i(bad), .badaddr_valid_i(bv), .medeleg_i(medeleg), .mideleg_i(mideleg),
    .stvec_i(stvec), .mtvec_i(mtvec), .cur_priv_i(cpriv), .cur_ie_i(cie),
    .pc_o(pc_o), .priv_o(priv_o), .ie_o(ie_o), .spie_o(spie_o), .spp_o(spp_o),
    .mpie_o(mpie_o), .mpp_o(mpp_o), .scause_o(sc_o), .sepc_o(se_o), .sbadaddr_o(sb_o),
    .mcause_o(mc_o), .mepc_o(me_o), .mbadaddr_o(mb_o), .resv_cancel_o(resv_o)
  );

  int checks = 0, failures = 0;
  bit done = 1'b0;

  // behavioural reference state
  logic [31:0] e_pc, e_sc, e_se, e_sb, e_mc, e_me, e_mb;
  logic [1:0]  e_priv, e_mpp;
  logic [2:0]  e_ie;
  logic        e_spie, e_spp, e_mpie, e_resv, e_idle;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_pc <= RPC; e_priv <= 2'd3; e_ie <= '0; e_spie <= 0; e_spp <= 0; e_mpie <= 0; e_mpp <= 0;
      e_sc <= 0; e_se <= 0; e_sb <= 0; e_mc <= 0; e_me <= 0; e_mb <= 0; e_resv <= 0; e_idle <= 1;
    end else begin
      e_resv <= trap;
      e_idle <= !trap;
      if (trap) begin
        longint unsigned idx;
        logic [31:0] msk;
        logic go_s, left;
        if (cause[31]) begin idx = longint'(cause & 32'h7fff_ffff); msk = mideleg; end
        else           begin idx = longint'(cause); msk = medeleg; end
        go_s = (cpriv < 2) && (idx < 32) && msk[idx[4:0]];
        left = (cpriv == 0) ? cie[0] : (cpriv == 1) ? cie[1] : cie[2];
        if (go_s) begin
          e_pc <= stvec; e_sc <= cause; e_se <= epc; if (bv) e_sb <= bad;
          e_spie <= left; e_spp <= cpriv[0]; e_priv <= 2'd1;
          e_ie <= cie & 3'b101;
        end else begin
          e_pc <= mtvec; e_mc <= cause; e_me <= epc; if (bv) e_mb <= bad;
          e_mpie <= left; e_mpp <= cpriv; e_priv <= 2'd3;
          e_ie <= cie & 3'b011;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string extra);
    chk({"R2 R8 priv ", extra}, 32'(priv_o), 32'(e_priv));
    chk({"R3 R4 pc ", extra}, pc_o, e_pc);
    chk({"R3 scause ", extra}, sc_o, e_sc);
    chk({"R3 sepc ", extra}, se_o, e_se);
    chk({"R4 mcause ", extra}, mc_o, e_mc);
    chk({"R4 mepc ", extra}, me_o, e_me);
    chk({"R5 sbad ", extra}, sb_o, e_sb);
    chk({"R5 mbad ", extra}, mb_o, e_mb);
    chk({"R6 spie ", extra}, 32'(spie_o), 32'(e_spie));
    chk({"R6 mpie ", extra}, 32'(mpie_o), 32'(e_mpie));
    chk({"R7 spp ", extra}, 32'(spp_o), 32'(e_spp));
    chk({"R7 mpp ", extra}, 32'(mpp_o), 32'(e_mpp));
    chk({"R7 ie ", extra}, 32'(ie_o), 32'(e_ie));
    chk({"R8 resv ", extra}, 32'(resv_o), 32'(e_resv));
  endtask

  bit run_cmp = 1'b0;
  always @(negedge clk) if (run_cmp) compare_all(e_idle ? "R9 idle" : "R1 entry");

  task automatic do_trap(input logic [31:0] c, input logic [1:0] p, input logic [2:0] ie,
                         input logic [31:0] med, input logic [31:0] mid, input logic v);
    @(negedge clk);
    trap = 1; cause = c; cpriv = p; cie = ie; medeleg = med; mideleg = mid; bv = v;
    epc = $urandom; bad = $urandom; stvec = $urandom & 32'hffff_fffc; mtvec = $urandom & 32'hffff_fffc;
    @(negedge clk);
    trap = 0; epc = $urandom; bad = $urandom; cause = $urandom;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset values
    chk("R10 pc", pc_o, RPC);
    chk("R10 priv", 32'(priv_o), 32'd3);
    chk("R10 records", sc_o | se_o | sb_o | mc_o | me_o | mb_o, 32'd0);
    chk("R10 status", {25'd0, ie_o, spie_o, spp_o, mpie_o, mpp_o}, 32'd0);
    chk("R10 resv", 32'(resv_o), 32'd0);
    rst_n = 1'b1;
    run_cmp = 1'b1;
    @(negedge clk);
    do_trap(32'd2, 2'd3, 3'b111, 32'hffff_ffff, 32'hffff_ffff, 1); // M priv never delegates
    do_trap(32'd2, 2'd1, 3'b111, 32'h0000_0004, 32'h0, 1);          // S, delegated exception
    do_trap(32'd5, 2'd0, 3'b001, 32'h0000_0004, 32'h0, 0);          // U, not delegated, no bad
    do_trap(32'h8000_0005, 2'd0, 3'b110, 32'h0, 32'h0000_0020, 1);   // interrupt mask used
    do_trap(32'h8000_0005, 2'd1, 3'b010, 32'h0000_0020, 32'h0, 1);   // R1: exception mask ignored
    do_trap(32'd40, 2'd0, 3'b111, 32'hffff_ffff, 32'hffff_ffff, 1);  // index past XLEN
    do_trap(32'h8000_0040, 2'd1, 3'b111, 32'hffff_ffff, 32'hffff_ffff, 1);
    do_trap(32'd3, 2'd2, 3'b100, 32'hffff_ffff, 32'hffff_ffff, 1);   // code 2 goes machine
    do_trap(32'd7, 2'd1, 3'b011, 32'h0000_0080, 32'h0, 0);          // S entry, bad kept
    for (int i = 0; i < 400; i++) begin
      logic [31:0] c;
      c = $urandom_range(0, 47);
      if ($urandom_range(0, 1) == 1) c[31] = 1'b1;
      do_trap(c, 2'($urandom_range(0, 3)), 3'($urandom), $urandom, $urandom, 1'($urandom));
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end
    // back-to-back strobes
    @(negedge clk);
    trap = 1; cause = 32'd1; cpriv = 2'd0; cie = 3'b111; medeleg = 32'h2; mideleg = 0; bv = 1; epc = 32'h40; bad = 32'h44;
    stvec = 32'h200; mtvec = 32'h300;
    @(negedge clk);
    cause = 32'd1; cpriv = 2'd1; epc = 32'h80; bad = 32'h88; medeleg = 0;
    @(negedge clk);
    trap = 0;
    repeat (3) @(negedge clk);
    run_cmp = 1'b0;
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule